// File: doc/BRIEF.md
# Receive Frame Queue with Word Readout

This block buffers whole receive frames arriving on a byte-wide stream that marks the first and last byte of each frame. Each accepted frame is kept in one slot of a circular ring. The ring has `NUM_SLOTS` slots (default 31), and each slot holds `SLOT_BYTES` bytes (default 256; the parameter may be raised to 2048). The stored image of a frame has three parts. It starts with a two-byte length, then holds the received bytes, and ends with a four-byte checksum. Reads past the end of the checksum, up to the next word boundary, return zeros.

Software drains the ring one 32-bit word at a time through a data register. Each read steps through the oldest frame. After the last word of that frame, the next read moves to the following frame. A small register window provides four things: a status flag that is set whenever a frame is accepted, a control register with a receive enable and a self-clearing flush bit, the data register, and a read-only count of pending frames. The `irq` output follows the status flag.

Top module: `rxq_frame_queue`

## Requirements
- R1: A frame whose first byte arrives while receive is enabled (CTRL bit 0) and fewer than `NUM_SLOTS` frames are pending is stored, and the pending count (register 3) rises by one after its last byte.
- R2: A frame whose first byte arrives while receive is disabled is discarded entirely, and the pending count does not change.
- R3: A frame arriving while `NUM_SLOTS` frames are pending is discarded; the count stays at `NUM_SLOTS` and the queued frames read back unchanged.
- R4: Image bytes 0 and 1 hold the stored length, which is the number of kept data bytes plus 6, low byte at image byte 0. The data bytes follow from image byte 2 onward.
- R5: The four bytes after the data hold a CRC-32 over the kept data bytes, least significant byte first. The CRC uses reflected polynomial 0xEDB88320, initial value all ones and a final inversion.
- R6: Image bytes past the stored length, up to the next multiple of 4, read as zero.
- R7: A read of register 2 returns image bytes offset..offset+3, with the lowest-offset byte in bits 7:0, and raises the offset by 4. When the raised offset reaches or passes the stored length, the offset returns to 0, the head moves to the next slot, and the count falls by one.
- R8: A read of register 2 while no frame is pending returns zero and leaves the count and the offset unchanged.
- R9: Writing CTRL with bit 4 set clears the pending count and the read offset and abandons a frame being received. CTRL bit 0 is taken from the same write and reads back; bit 4 reads as 0.
- R10: Register 3 returns the pending count, and writes to it are ignored.
- R11: Register 0 bit 0 is set by every accepted frame and cleared by writing 1 to it; a new frame in the same cycle wins. The `irq` output equals this bit.
- R12: Data bytes beyond `SLOT_BYTES - 6` are not stored and are left out of the length and the CRC.
- R13: Slots are reused in ring order modulo `NUM_SLOTS`. A frame that completes in the same cycle as the read that releases a frame leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Receive byte present this cycle |
| in_first | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame |
| in_byte | input | 8 | Receive byte |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 status, 1 control, 2 data, 3 count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| irq | output | 1 | Frame-received flag |

## Verification
The bound checker checks these rules on every clock: the pending count never exceeds the slot count, and the read offset stays word aligned. It also checks that a data read steps the offset by 4, that a read of an empty queue returns zero and moves nothing, that a flush empties the queue, that a write to the count register leaves the count unchanged, and that the count nets out when a completion and a release happen together. Only the bench's scenarios can show whether the content is right. Those scenarios cover the length header, the data order, the CRC value, zero padding, truncation, drops on a full ring, and frames read back in order after the ring wraps.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int DEF_SLOTS      = 31;
    localparam int DEF_SLOT_BYTES = 256;
    localparam int HDR_BYTES      = 2;
    localparam int CRC_BYTES      = 4;
    localparam int FRAME_OVERHEAD = HDR_BYTES + CRC_BYTES;

    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_FLUSH_BIT = 4;
    localparam int STAT_RX_BIT    = 0;

    typedef enum logic [1:0] {
        REG_STAT  = 2'd0,
        REG_CTRL  = 2'd1,
        REG_DATA  = 2'd2,
        REG_COUNT = 2'd3
    } rxq_reg_e;

    typedef struct packed {
        logic       valid;
        logic       first;
        logic       last;
        logic [7:0] data;
    } rxq_beat_t;

    // one byte through the reflected CRC-32 register
    function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                               input logic [7:0]  byte_in);
        logic [31:0] c;
        c = crc_in ^ {24'h0, byte_in};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/rxq_writer.sv
module rxq_writer
    import rxq_pkg::*;
#(
    parameter int NUM_SLOTS  = DEF_SLOTS,
    parameter int SLOT_BYTES = DEF_SLOT_BYTES,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int LEN_W     = $clog2(SLOT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  rxq_beat_t         beat,
    input  logic              enable,
    input  logic              space_ok,
    input  logic              flush,
    input  logic [SLOT_W-1:0] tail_slot,
    output logic              mem_we,
    output logic [SLOT_W-1:0] mem_slot,
    output logic [LEN_W-1:0]  mem_pos,
    output logic [7:0]        mem_byte,
    output logic              commit,
    output logic [SLOT_W-1:0] commit_slot,
    output logic [LEN_W-1:0]  commit_len,
    output logic [31:0]       commit_crc
);

    localparam int MAX_DATA = SLOT_BYTES - FRAME_OVERHEAD;
    localparam logic [LEN_W-1:0] MAXD  = LEN_W'(MAX_DATA);
    localparam logic [LEN_W-1:0] HDR_L = LEN_W'(HDR_BYTES);
    localparam logic [LEN_W-1:0] OVH_L = LEN_W'(FRAME_OVERHEAD);

    logic              active_q;
    logic [SLOT_W-1:0] slot_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [31:0]       crc_q;

    logic              start, take, room;
    logic [SLOT_W-1:0] cur_slot;
    logic [LEN_W-1:0]  cur_cnt, cnt_nxt;
    logic [31:0]       cur_crc, crc_nxt;

    always_comb begin
        start    = beat.valid && beat.first && enable && space_ok && !flush;
        take     = beat.valid && (start || (active_q && !beat.first && !flush));
        cur_slot = start ? tail_slot : slot_q;
        cur_cnt  = start ? '0 : cnt_q;
        cur_crc  = start ? CRC_SEED : crc_q;
        room     = cur_cnt < MAXD;
        crc_nxt  = room ? crc32_step(cur_crc, beat.data) : cur_crc;
        cnt_nxt  = room ? cur_cnt + LEN_W'(1) : cur_cnt;
    end

    assign mem_we      = take && room;
    assign mem_slot    = cur_slot;
    assign mem_pos     = cur_cnt + HDR_L;
    assign mem_byte    = beat.data;
    assign commit      = take && beat.last;
    assign commit_slot = cur_slot;
    assign commit_len  = cnt_nxt + OVH_L;
    assign commit_crc  = ~crc_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            slot_q   <= '0;
            cnt_q    <= '0;
            crc_q    <= CRC_SEED;
        end else begin
            if (flush) begin
                active_q <= 1'b0;
            end else if (beat.valid) begin
                if (beat.first) begin
                    active_q <= start && !beat.last;
                end else if (active_q && beat.last) begin
                    active_q <= 1'b0;
                end
            end
            if (take) begin
                slot_q <= cur_slot;
                cnt_q  <= cnt_nxt;
                crc_q  <= crc_nxt;
            end
        end
    end

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int NUM_SLOTS  = DEF_SLOTS,
    parameter int SLOT_BYTES = DEF_SLOT_BYTES,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int LEN_W     = $clog2(SLOT_BYTES + 1),
    localparam int SLOT_WORDS = SLOT_BYTES / 4,
    localparam int DEPTH     = NUM_SLOTS * SLOT_WORDS,
    localparam int MEM_AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [LEN_W-1:0]  wr_pos,
    input  logic [7:0]        wr_byte,
    input  logic              commit,
    input  logic [SLOT_W-1:0] commit_slot,
    input  logic [LEN_W-1:0]  commit_len,
    input  logic [31:0]       commit_crc,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [LEN_W-1:0]  rd_off,
    output logic [LEN_W-1:0]  head_len,
    output logic [31:0]       rd_word
);

    localparam int BW = LEN_W + 1;

    logic [LEN_W-1:0] len_q [NUM_SLOTS];
    logic [31:0]      crc_q [NUM_SLOTS];

    always_ff @(posedge clk) begin
        if (commit) begin
            len_q[commit_slot] <= commit_len;
            crc_q[commit_slot] <= commit_crc;
        end
    end

    logic [MEM_AW-1:0] waddr, raddr;
    assign waddr = MEM_AW'(wr_slot) * MEM_AW'(SLOT_WORDS) + MEM_AW'(wr_pos >> 2);
    assign raddr = MEM_AW'(rd_slot) * MEM_AW'(SLOT_WORDS) + MEM_AW'(rd_off >> 2);

    logic [31:0] head_crc;
    logic [15:0] len16;
    logic [BW-1:0] len_x, data_end;
    assign head_len = len_q[rd_slot];
    assign head_crc = crc_q[rd_slot];
    assign len16    = 16'(head_len);
    assign len_x    = BW'(head_len);
    assign data_end = len_x - BW'(CRC_BYTES);

    for (genvar l = 0; l < 4; l++) begin : g_lane
        logic [7:0] mem [DEPTH];
        logic [7:0] lane_q;
        logic [BW-1:0] b, k;

        always_ff @(posedge clk) begin
            if (wr_en && (wr_pos[1:0] == 2'(l))) begin
                mem[waddr] <= wr_byte;
            end
        end
        assign lane_q = mem[raddr];
        assign b      = BW'(rd_off) + BW'(l);
        assign k      = b - data_end;

        always_comb begin
            if (b < BW'(HDR_BYTES)) begin
                rd_word[8*l +: 8] = b[0] ? len16[15:8] : len16[7:0];
            end else if (b < data_end) begin
                rd_word[8*l +: 8] = lane_q;
            end else if (b < len_x) begin
                case (k[1:0])
                    2'd0:    rd_word[8*l +: 8] = head_crc[7:0];
                    2'd1:    rd_word[8*l +: 8] = head_crc[15:8];
                    2'd2:    rd_word[8*l +: 8] = head_crc[23:16];
                    default: rd_word[8*l +: 8] = head_crc[31:24];
                endcase
            end else begin
                rd_word[8*l +: 8] = 8'h00;
            end
        end
    end

endmodule

// File: rtl/rxq_ring.sv
module rxq_ring
    import rxq_pkg::*;
#(
    parameter int NUM_SLOTS  = DEF_SLOTS,
    parameter int SLOT_BYTES = DEF_SLOT_BYTES,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int CNT_W     = $clog2(NUM_SLOTS + 1),
    localparam int LEN_W     = $clog2(SLOT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic              pop,
    input  logic              flush,
    input  logic [LEN_W-1:0]  head_len,
    output logic [SLOT_W-1:0] head,
    output logic [SLOT_W-1:0] tail,
    output logic [CNT_W-1:0]  count,
    output logic [LEN_W-1:0]  offset
);

    localparam int SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0]  N_SUM   = SUM_W'(NUM_SLOTS);
    localparam logic [SLOT_W-1:0] LAST_SL = SLOT_W'(NUM_SLOTS - 1);

    logic [SLOT_W-1:0] head_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [LEN_W-1:0]  off_q;

    logic [SUM_W-1:0] sum;
    logic [LEN_W:0]   off_step;
    logic             done;

    assign sum      = SUM_W'(head_q) + SUM_W'(cnt_q);
    assign tail     = (sum >= N_SUM) ? SLOT_W'(sum - N_SUM) : SLOT_W'(sum);
    assign off_step = {1'b0, off_q} + (LEN_W+1)'(4);
    assign done     = pop && (off_step >= {1'b0, head_len});

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            cnt_q  <= '0;
            off_q  <= '0;
        end else if (flush) begin
            cnt_q <= '0;
            off_q <= '0;
        end else begin
            if (pop) begin
                if (done) begin
                    off_q  <= '0;
                    head_q <= (head_q == LAST_SL) ? '0 : head_q + SLOT_W'(1);
                end else begin
                    off_q <= LEN_W'(off_step);
                end
            end
            if (commit && !done) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end else if (done && !commit) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign head   = head_q;
    assign count  = cnt_q;
    assign offset = off_q;

endmodule

// File: rtl/rxq_frame_queue.sv
module rxq_frame_queue
    import rxq_pkg::*;
#(
    parameter int NUM_SLOTS  = DEF_SLOTS,
    parameter int SLOT_BYTES = DEF_SLOT_BYTES
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_first,
    input  logic        in_last,
    input  logic [7:0]  in_byte,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);

    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int CNT_W  = $clog2(NUM_SLOTS + 1);
    localparam int LEN_W  = $clog2(SLOT_BYTES + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_SLOTS);

    rxq_reg_e  reg_sel;
    rxq_beat_t beat;
    logic      enable_q, flag_q;
    logic      flush, pop, ack;

    logic              mem_we, commit;
    logic [SLOT_W-1:0] mem_slot, commit_slot, head, tail;
    logic [LEN_W-1:0]  mem_pos, commit_len, head_len, offset;
    logic [7:0]        mem_byte;
    logic [31:0]       commit_crc, rd_word;
    logic [CNT_W-1:0]  count;

    logic unused_wdata;
    assign unused_wdata = ^{bus_wdata[31:5], bus_wdata[3:1]};

    assign reg_sel = rxq_reg_e'(bus_addr);
    assign beat    = '{valid: in_valid, first: in_first, last: in_last, data: in_byte};
    assign flush   = bus_wr && (reg_sel == REG_CTRL) && bus_wdata[CTRL_FLUSH_BIT];
    assign ack     = bus_wr && (reg_sel == REG_STAT) && bus_wdata[STAT_RX_BIT];
    assign pop     = bus_rd && (reg_sel == REG_DATA) && (count != '0);

    rxq_writer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_writer (
        .clk(clk), .rst(rst), .beat(beat), .enable(enable_q),
        .space_ok(count < FULL), .flush(flush), .tail_slot(tail),
        .mem_we(mem_we), .mem_slot(mem_slot), .mem_pos(mem_pos), .mem_byte(mem_byte),
        .commit(commit), .commit_slot(commit_slot), .commit_len(commit_len),
        .commit_crc(commit_crc)
    );

    rxq_store #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_store (
        .clk(clk), .wr_en(mem_we), .wr_slot(mem_slot), .wr_pos(mem_pos),
        .wr_byte(mem_byte), .commit(commit), .commit_slot(commit_slot),
        .commit_len(commit_len), .commit_crc(commit_crc), .rd_slot(head),
        .rd_off(offset), .head_len(head_len), .rd_word(rd_word)
    );

    rxq_ring #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_ring (
        .clk(clk), .rst(rst), .commit(commit), .pop(pop), .flush(flush),
        .head_len(head_len), .head(head), .tail(tail), .count(count), .offset(offset)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            if (bus_wr && (reg_sel == REG_CTRL)) begin
                enable_q <= bus_wdata[CTRL_EN_BIT];
            end
            if (commit) begin
                flag_q <= 1'b1;
            end else if (ack) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (reg_sel)
            REG_STAT:  bus_rdata[STAT_RX_BIT] = flag_q;
            REG_CTRL:  bus_rdata[CTRL_EN_BIT] = enable_q;
            REG_DATA:  bus_rdata = (count != '0) ? rd_word : 32'h0;
            default:   bus_rdata = 32'(count);
        endcase
    end

    assign irq = flag_q;

endmodule

// File: rtl/rxq_frame_queue_chk.sv
module rxq_frame_queue_chk
    import rxq_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    parameter int CNT_W     = 5,
    parameter int LEN_W     = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             irq,
    input logic             commit,
    input logic [CNT_W-1:0] count,
    input logic [LEN_W-1:0] offset,
    input logic [LEN_W-1:0] head_len
);

    logic rd_data, empty, pop_step, pop_done;
    assign rd_data  = bus_rd && (bus_addr == REG_DATA);
    assign empty    = (count == '0);
    assign pop_step = rd_data && !empty && (({1'b0, offset} + (LEN_W+1)'(4)) <  {1'b0, head_len});
    assign pop_done = rd_data && !empty && (({1'b0, offset} + (LEN_W+1)'(4)) >= {1'b0, head_len});

    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(NUM_SLOTS));

    p_offset_align_r7: assert property (@(posedge clk) disable iff (rst)
        offset[1:0] == 2'b00);

    p_offset_step_r7: assert property (@(posedge clk) disable iff (rst)
        pop_step |=> (offset == $past(offset) + LEN_W'(4)));

    p_empty_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_data && empty) |-> (bus_rdata == 32'h0));

    p_empty_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_data && empty && !commit) |=> (count == '0 && $stable(offset)));

    p_flush_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_CTRL && bus_wdata[CTRL_FLUSH_BIT]) |=> (count == '0 && offset == '0));

    p_count_ro_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_COUNT && !commit) |=> $stable(count));

    p_irq_set_r11: assert property (@(posedge clk) disable iff (rst)
        commit |=> irq);

    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        (pop_done && !commit) |=> (count == $past(count) - CNT_W'(1) && offset == '0));

    p_net_count_r13: assert property (@(posedge clk) disable iff (rst)
        (pop_done && commit) |=> $stable(count));

endmodule

bind rxq_frame_queue rxq_frame_queue_chk #(
    .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .commit(commit),
    .count(count), .offset(offset), .head_len(head_len)
);

// File: tb/rxq_frame_queue_tb.sv
module rxq_frame_queue_tb;

    localparam int NSL  = 31;
    localparam int SB   = 256;
    localparam int MAXD = SB - 6;
    localparam int NV   = 8;
    localparam int VEC_LEN  [NV] = '{1, 2, 3, 4, 5, 14, 61, 300};
    localparam int VEC_SEED [NV] = '{3, 9, 17, 22, 40, 51, 77, 88};

    logic        clk = 0, rst = 1;
    logic        in_valid = 0, in_first = 0, in_last = 0;
    logic [7:0]  in_byte = 0;
    logic        bus_rd = 0, bus_wr = 0;
    logic [1:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    rxq_frame_queue u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
        .in_byte(in_byte), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [7:0] gen(input int seed, input int j);
        return 8'((seed * 13 + j * 7 + j / 5) & 255);
    endfunction

    function automatic logic [31:0] ref_crc(input int seed, input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int j = 0; j < n; j++) begin
            c = c ^ {24'h0, gen(seed, j)};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic logic [7:0] img(input int k, input int n, input int seed, input logic [31:0] c);
        int L = n + 6;
        if (k == 0) return 8'(L & 255);
        if (k == 1) return 8'(L >> 8);
        if (k < 2 + n) return gen(seed, k - 2);
        if (k < L) return c[8*(k-2-n) +: 8];
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive_byte(input int seed, input int j, input int len);
        @(negedge clk);
        in_valid = 1; in_first = (j == 0); in_last = (j == len - 1); in_byte = gen(seed, j);
    endtask

    task automatic send(input int len, input int seed);
        for (int j = 0; j < len; j++) drive_byte(seed, j, len);
        @(negedge clk);
        in_valid = 0; in_first = 0; in_last = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #5 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(posedge clk);
        #1 bus_wr = 0;
    endtask

    task automatic expect_words(input int len, input int seed, input int w0, input int w1, input string tag);
        int n = (len > MAXD) ? MAXD : len;
        logic [31:0] c = ref_crc(seed, n);
        logic [31:0] got, exp;
        for (int w = w0; w < w1; w++) begin
            for (int i = 0; i < 4; i++) exp[8*i +: 8] = img(4*w + i, n, seed, c);
            bus_read(2'd2, got);
            chk($sformatf("%s word %0d", tag, w), got, exp);
        end
    endtask

    task automatic expect_frame(input int len, input int seed, input string tag);
        int n = (len > MAXD) ? MAXD : len;
        expect_words(len, seed, 0, (n + 9) / 4, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 0;

        // reset state
        bus_read(2'd3, d); chk("R10 reset count", d, 0);
        bus_read(2'd0, d); chk("R11 reset status", d, 0);
        chk("R11 reset irq", 32'(irq), 0);
        bus_read(2'd1, d); chk("R9 reset ctrl", d, 0);
        bus_read(2'd2, d); chk("R8 empty read data", d, 0);
        bus_read(2'd3, d); chk("R8 empty read count", d, 0);

        // disabled receive
        send(6, 5);
        bus_read(2'd3, d); chk("R2 disabled count", d, 0);
        chk("R2 disabled irq", 32'(irq), 0);

        bus_write(2'd1, 32'h1);
        bus_read(2'd1, d); chk("R9 ctrl readback", d, 1);

        // vector table: frame sizes with their seeds
        for (int v = 0; v < NV; v++) begin
            send(VEC_LEN[v], VEC_SEED[v]);
            bus_read(2'd3, d); chk($sformatf("R1 count vec %0d", v), d, 1);
            bus_read(2'd0, d); chk($sformatf("R11 status vec %0d", v), d, 1);
            chk($sformatf("R11 irq vec %0d", v), 32'(irq), 1);
            bus_write(2'd0, 32'h1);
            chk($sformatf("R11 ack vec %0d", v), 32'(irq), 0);
            expect_frame(VEC_LEN[v], VEC_SEED[v],
                         VEC_LEN[v] > MAXD ? "R12 truncated image" : "R4 R5 R6 R7 image");
            bus_read(2'd3, d); chk($sformatf("R7 drained vec %0d", v), d, 0);
        end

        // fill the ring past the end, then one more frame is dropped
        for (int i = 0; i < NSL; i++) send(1 + i, 100 + i);
        bus_read(2'd3, d); chk("R3 full count", d, NSL);
        send(9, 200);
        bus_read(2'd3, d); chk("R3 drop count", d, NSL);
        for (int i = 0; i < NSL; i++) expect_frame(1 + i, 100 + i, "R3 R13 ring order");
        bus_read(2'd3, d); chk("R13 ring drained", d, 0);
        bus_read(2'd2, d); chk("R8 empty after drain", d, 0);

        // completion and release in the same cycle
        send(5, 31);
        expect_words(5, 31, 0, 2, "R7 partial");
        for (int j = 0; j < 6; j++) drive_byte(44, j, 7);
        @(negedge clk);
        in_valid = 1; in_first = 0; in_last = 1; in_byte = gen(44, 6);
        bus_addr = 2'd2; bus_rd = 1;
        #5 chk("R6 R7 final word", bus_rdata, {8'h00, ref_crc(31, 5)[31:8]});
        @(posedge clk);
        #1 bus_rd = 0; in_valid = 0; in_last = 0;
        bus_read(2'd3, d); chk("R13 net count", d, 1);
        expect_frame(7, 44, "R13 frame after overlap");

        // flush
        send(10, 60);
        send(12, 61);
        bus_read(2'd2, d);
        bus_write(2'd1, 32'h11);
        bus_read(2'd3, d); chk("R9 flush count", d, 0);
        bus_read(2'd1, d); chk("R9 flush bit reads 0", d, 1);
        send(8, 62);
        expect_frame(8, 62, "R9 offset cleared");

        // count register ignores writes
        send(3, 70);
        bus_write(2'd3, 32'h1F);
        bus_read(2'd3, d); chk("R10 write ignored", d, 1);
        expect_frame(3, 70, "R10 frame intact");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule